// File: doc/BRIEF.md
# Serial Debug Command Framer

This block is the serial front end of a background debug port. A host clocks 17-bit transfers over a synchronous bit-serial link, one bit per strobe. Each input transfer carries a leading bit that the block ignores, followed by a 16-bit word sent MSB first. The block groups these words into commands. A command is an operation word followed by zero to four extension words. The operation word's three low bits give the extension count.

When the last word of a command arrives, the block offers the command on a valid/ready interface to the execution side. It then waits for a single result on a second valid/ready interface. A result that arrives mid-transfer is held in a one-entry buffer. It is shifted out on the next transfer, while the host is already sending the next command. Every outgoing transfer begins with a status bit, where 1 means "not ready or error", followed by 16 data bits MSB first. When nothing is owed, the block sends an all-ones idle word. Dropping the debug-enable input abandons any partial transfer or command.

Top module: `dbgf_framer`

## Requirements
- R1: After reset, `cmd_valid` and `res_ready` are low and `bit_out` presents the idle frame: status 0, data 16'hFFFF.
- R2: A transfer is 17 bit strobes. `bit_out` shows the frame's status bit before the first strobe, then data bits 15 down to 0. The input bit on a frame's first strobe is ignored, and the next 16 input bits form the word MSB first.
- R3: An operation word's bits [2:0] give the extension count (0..4). The command is offered after the operation word plus that many extension words. `cmd_op` is the operation word and `cmd_next` the count. Extension slot i sits at `cmd_ext[16*i+15:16*i]` in arrival order, and unused slots read zero.
- R4: `cmd_valid` rises on the cycle after the strobe that completes a command. It stays high, with `cmd_op`, `cmd_ext` and `cmd_next` unchanged, until a cycle with `cmd_ready` high.
- R5: A frame that starts while a command is complete but its result is not yet buffered carries the busy frame: status 1, data 16'h0000.
- R6: A result taken on the result handshake is sent, with status 0 and the result as data, on the first frame that starts after it was taken. Until then it is held.
- R7: An operation word with count 5..7 is illegal and offers no command. The error frame (status 1, data 16'h0001) follows on the next frame, or one frame later if a buffered result is sent first.
- R8: Words that complete while a command is offered or executing are discarded. The next word accepted after the result is taken is treated as an operation word.
- R9: A frame that starts with no result, error or command outstanding carries the idle frame, including between extension words.
- R10: While `dbg_en` is low, `bit_out` shows the idle frame's status bit and strobes are ignored. On re-enable, the next strobe begins a new frame, and any partly assembled command is abandoned.
- R11: `res_ready` is high only while a dispatched command awaits its result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dbg_en | input | 1 | Debug mode enable; low clears the serial state |
| bit_stb | input | 1 | One-cycle strobe per serial bit |
| bit_in | input | 1 | Serial input bit, sampled on `bit_stb` |
| bit_out | output | 1 | Serial output bit for the current strobe |
| cmd_valid | output | 1 | Assembled command offered |
| cmd_ready | input | 1 | Execution side accepts the command |
| cmd_op | output | 16 | Operation word |
| cmd_ext | output | 64 | Extension words, slot 0 in the low 16 bits |
| cmd_next | output | 3 | Number of extension words |
| res_valid | input | 1 | Result offered |
| res_ready | output | 1 | Result can be taken |
| res_data | input | 16 | Result word |

## Verification
The assertions assume that the execution side holds a result stable while `res_valid` is high. They also assume the host pulses `bit_stb` for a single cycle per bit, and does not change `dbg_en` in the cycle it strobes. The stimulus keeps within these rules as follows. The bench drives each serial bit as a one-cycle strobe, with an idle cycle between strobes. A result is raised only after its command's handshake and is held until it is taken. `dbg_en` is lowered only between strobes. Execution latency and ready stalls vary per command, so that results land both inside the next transfer and two transfers later.

// File: rtl/dbgf_pkg.sv
package dbgf_pkg;
   typedef enum logic [1:0] {
      ST_ASM  = 2'd0,
      ST_DISP = 2'd1,
      ST_WAIT = 2'd2
   } dbgf_state_e;

   typedef enum logic [1:0] {
      FK_IDLE = 2'd0,
      FK_BUSY = 2'd1,
      FK_ERR  = 2'd2,
      FK_RES  = 2'd3
   } dbgf_kind_e;
endpackage

// File: rtl/dbgf_shifter.sv
module dbgf_shifter #(
   parameter int WORD_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              dbg_en,
   input  logic              bit_stb,
   input  logic              bit_in,
   input  logic [WORD_W:0]   load_frame,
   output logic              bit_out,
   output logic              word_stb,
   output logic [WORD_W-1:0] word_data
);
   localparam int FRAME_W = WORD_W + 1;
   localparam int BC_W    = $clog2(FRAME_W);
   localparam logic [BC_W-1:0]    LAST       = BC_W'(FRAME_W - 1);
   localparam logic [FRAME_W-1:0] IDLE_FRAME = {1'b0, {WORD_W{1'b1}}};

   if (WORD_W < 2) begin : g_bad_width
      $error("dbgf_shifter: WORD_W must be at least 2");
   end

   logic [BC_W-1:0]    bcnt;
   logic [WORD_W-1:0]  rx_sr;
   logic [FRAME_W-1:0] tx_sr;

   assign word_stb  = dbg_en && bit_stb && (bcnt == LAST);
   assign word_data = {rx_sr[WORD_W-2:0], bit_in};
   assign bit_out   = tx_sr[FRAME_W-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bcnt  <= '0;
         rx_sr <= '0;
         tx_sr <= IDLE_FRAME;
      end else if (!dbg_en) begin
         bcnt  <= '0;
         rx_sr <= '0;
         tx_sr <= IDLE_FRAME;
      end else if (bit_stb) begin
         rx_sr <= {rx_sr[WORD_W-2:0], bit_in};
         if (bcnt == LAST) begin
            bcnt  <= '0;
            tx_sr <= load_frame;
         end else begin
            bcnt  <= bcnt + 1'b1;
            tx_sr <= {tx_sr[FRAME_W-2:0], 1'b0};
         end
      end
   end

   AST_STATUS_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
      word_stb |=> bit_out == $past(load_frame[FRAME_W-1])); // R2
   AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (dbg_en && !bit_stb) |=> $stable(bit_out)); // R2
endmodule

// File: rtl/dbgf_assembler.sv
module dbgf_assembler
   import dbgf_pkg::*;
#(
   parameter int WORD_W  = 16,
   parameter int CNT_W   = 3,
   parameter int MAX_EXT = 4
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      dbg_en,
   input  logic                      word_stb,
   input  logic [WORD_W-1:0]         word_data,
   input  logic                      res_take,
   output logic                      cmd_valid,
   input  logic                      cmd_ready,
   output logic [WORD_W-1:0]         cmd_op,
   output logic [MAX_EXT*WORD_W-1:0] cmd_ext,
   output logic [CNT_W-1:0]          cmd_next,
   output logic                      outstanding,
   output logic                      awaiting,
   output logic                      complete_now,
   output logic                      illegal_now
);
   if (MAX_EXT < 1 || MAX_EXT >= (1 << CNT_W)) begin : g_bad_ext
      $error("dbgf_assembler: MAX_EXT must lie in 1 .. 2**CNT_W-1");
   end
   if (CNT_W > WORD_W) begin : g_bad_cnt
      $error("dbgf_assembler: count field wider than a word");
   end

   dbgf_state_e       st;
   logic [CNT_W-1:0]  widx;
   logic [CNT_W-1:0]  need_q;
   logic [WORD_W-1:0] op_q;
   logic [CNT_W-1:0]  op_cnt;
   logic              taking;
   logic              at_op;

   assign op_cnt       = word_data[CNT_W-1:0];
   assign taking       = word_stb && (st == ST_ASM);
   assign at_op        = (widx == '0);
   assign illegal_now  = taking && at_op && (int'(op_cnt) > MAX_EXT);
   assign complete_now = taking && (at_op ? (op_cnt == '0) : (widx == need_q));

   for (genvar g = 0; g < MAX_EXT; g++) begin : g_slot
      logic [WORD_W-1:0] ext_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            ext_q <= '0;
         else if (taking && at_op)
            ext_q <= '0;
         else if (taking && (widx == CNT_W'(g + 1)))
            ext_q <= word_data;
      end
      assign cmd_ext[g*WORD_W +: WORD_W] = ext_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st     <= ST_ASM;
         widx   <= '0;
         need_q <= '0;
         op_q   <= '0;
      end else begin
         if (!dbg_en) begin
            widx <= '0;
         end else if (taking) begin
            if (at_op) begin
               if (!illegal_now) begin
                  op_q   <= word_data;
                  need_q <= op_cnt;
                  widx   <= (op_cnt == '0) ? '0 : CNT_W'(1);
               end
            end else begin
               widx <= complete_now ? '0 : widx + 1'b1;
            end
         end
         case (st)
            ST_ASM:  if (complete_now) st <= ST_DISP;
            ST_DISP: if (cmd_ready)    st <= ST_WAIT;
            ST_WAIT: if (res_take)     st <= ST_ASM;
            default: st <= ST_ASM;
         endcase
      end
   end

   assign cmd_valid   = (st == ST_DISP);
   assign cmd_op      = op_q;
   assign cmd_next    = need_q;
   assign outstanding = (st != ST_ASM);
   assign awaiting    = (st == ST_WAIT);

   AST_CMD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_op) && $stable(cmd_ext) && $stable(cmd_next))); // R4
   AST_ILLEGAL_NO_DISPATCH: assert property (@(posedge clk) disable iff (!rst_n)
      illegal_now |=> !cmd_valid); // R7
   AST_COUNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid |-> (int'(cmd_next) <= MAX_EXT)); // R3
endmodule

// File: rtl/dbgf_respond.sv
module dbgf_respond
   import dbgf_pkg::*;
#(
   parameter int WORD_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              word_stb,
   input  logic              outstanding,
   input  logic              awaiting,
   input  logic              complete_now,
   input  logic              illegal_now,
   input  logic              res_valid,
   output logic              res_ready,
   input  logic [WORD_W-1:0] res_data,
   output logic              res_take,
   output logic [WORD_W:0]   load_frame
);
   localparam logic [WORD_W-1:0] IDLE_DATA = {WORD_W{1'b1}};
   localparam logic [WORD_W-1:0] BUSY_DATA = '0;
   localparam logic [WORD_W-1:0] ERR_DATA  = WORD_W'(1);

   logic              res_full;
   logic [WORD_W-1:0] res_buf;
   logic              err_pend;
   dbgf_kind_e        kind;

   assign res_ready = awaiting && !res_full;
   assign res_take  = res_valid && res_ready;

   always_comb begin
      if (res_full)
         kind = FK_RES;
      else if (err_pend || illegal_now)
         kind = FK_ERR;
      else if (outstanding || complete_now)
         kind = FK_BUSY;
      else
         kind = FK_IDLE;
      case (kind)
         FK_RES:  load_frame = {1'b0, res_buf};
         FK_ERR:  load_frame = {1'b1, ERR_DATA};
         FK_BUSY: load_frame = {1'b1, BUSY_DATA};
         default: load_frame = {1'b0, IDLE_DATA};
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         res_full <= 1'b0;
         res_buf  <= '0;
         err_pend <= 1'b0;
      end else begin
         if (res_take) begin
            res_full <= 1'b1;
            res_buf  <= res_data;
         end else if (word_stb) begin
            res_full <= 1'b0;
         end
         if (word_stb)
            err_pend <= res_full && (err_pend || illegal_now);
      end
   end

   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      (res_full && !word_stb) |=> (res_full && $stable(res_buf))); // R6
endmodule

// File: rtl/dbgf_framer.sv
module dbgf_framer #(
   parameter int WORD_W  = 16,
   parameter int CNT_W   = 3,
   parameter int MAX_EXT = 4
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      dbg_en,
   input  logic                      bit_stb,
   input  logic                      bit_in,
   output logic                      bit_out,
   output logic                      cmd_valid,
   input  logic                      cmd_ready,
   output logic [WORD_W-1:0]         cmd_op,
   output logic [MAX_EXT*WORD_W-1:0] cmd_ext,
   output logic [CNT_W-1:0]          cmd_next,
   input  logic                      res_valid,
   output logic                      res_ready,
   input  logic [WORD_W-1:0]         res_data
);
   logic              word_stb;
   logic [WORD_W-1:0] word_data;
   logic [WORD_W:0]   load_frame;
   logic              res_take;
   logic              outstanding;
   logic              awaiting;
   logic              complete_now;
   logic              illegal_now;

   dbgf_shifter #(.WORD_W(WORD_W)) u_shift (
      .clk        (clk),
      .rst_n      (rst_n),
      .dbg_en     (dbg_en),
      .bit_stb    (bit_stb),
      .bit_in     (bit_in),
      .load_frame (load_frame),
      .bit_out    (bit_out),
      .word_stb   (word_stb),
      .word_data  (word_data)
   );

   dbgf_assembler #(.WORD_W(WORD_W), .CNT_W(CNT_W), .MAX_EXT(MAX_EXT)) u_asm (
      .clk          (clk),
      .rst_n        (rst_n),
      .dbg_en       (dbg_en),
      .word_stb     (word_stb),
      .word_data    (word_data),
      .res_take     (res_take),
      .cmd_valid    (cmd_valid),
      .cmd_ready    (cmd_ready),
      .cmd_op       (cmd_op),
      .cmd_ext      (cmd_ext),
      .cmd_next     (cmd_next),
      .outstanding  (outstanding),
      .awaiting     (awaiting),
      .complete_now (complete_now),
      .illegal_now  (illegal_now)
   );

   dbgf_respond #(.WORD_W(WORD_W)) u_resp (
      .clk          (clk),
      .rst_n        (rst_n),
      .word_stb     (word_stb),
      .outstanding  (outstanding),
      .awaiting     (awaiting),
      .complete_now (complete_now),
      .illegal_now  (illegal_now),
      .res_valid    (res_valid),
      .res_ready    (res_ready),
      .res_data     (res_data),
      .res_take     (res_take),
      .load_frame   (load_frame)
   );
endmodule

// File: tb/sim_dbgf_framer.sv
module sim_dbgf_framer;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        dbg_en = 1'b1;
   logic        bit_stb = 1'b0;
   logic        bit_in = 1'b0;
   logic        bit_out;
   logic        cmd_valid;
   logic        cmd_ready = 1'b0;
   logic [15:0] cmd_op;
   logic [63:0] cmd_ext;
   logic [2:0]  cmd_next;
   logic        res_valid = 1'b0;
   logic        res_ready;
   logic [15:0] res_data = '0;

   int n_chk  = 0;
   int n_fail = 0;
   bit in_exec = 1'b0;
   bit started = 1'b0;

   typedef struct packed {
      logic [15:0] op;
      logic [2:0]  n;
      logic [63:0] ext;
      logic [7:0]  lat;
      logic [7:0]  rdly;
   } exp_cmd_t;

   exp_cmd_t exp_q[$];

   localparam logic [16:0] F_IDLE = {1'b0, 16'hFFFF};
   localparam logic [16:0] F_BUSY = {1'b1, 16'h0000};
   localparam logic [16:0] F_ERR  = {1'b1, 16'h0001};

   always #2.5 clk = ~clk;

   dbgf_framer u0 (
      .clk(clk), .rst_n(rst_n), .dbg_en(dbg_en), .bit_stb(bit_stb), .bit_in(bit_in),
      .bit_out(bit_out), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
      .cmd_ext(cmd_ext), .cmd_next(cmd_next), .res_valid(res_valid), .res_ready(res_ready),
      .res_data(res_data)
   );

   function automatic logic [15:0] model_res(input logic [15:0] op, input logic [15:0] e0);
      return {op[7:0], op[15:8]} ^ e0;
   endfunction

   task automatic check(input logic [79:0] act, input logic [79:0] exp, input string tag);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic push_cmd(input logic [15:0] op, input logic [2:0] n, input logic [63:0] ext,
                           input logic [7:0] lat, input logic [7:0] rdly);
      exp_cmd_t c;
      c.op = op; c.n = n; c.ext = ext; c.lat = lat; c.rdly = rdly;
      exp_q.push_back(c);
   endtask

   task automatic xfer(input logic [15:0] w, input logic [16:0] exp, input string tag);
      logic [16:0] got;
      for (int i = 0; i < 17; i++) begin
         @(negedge clk);
         got[16-i] = bit_out;
         bit_in  = (i == 0) ? 1'b1 : w[16-i];
         bit_stb = 1'b1;
         @(negedge clk);
         bit_stb = 1'b0;
      end
      check({63'd0, got}, {63'd0, exp}, tag);
   endtask

   // Execution side model and scoreboard monitor
   initial begin
      exp_cmd_t c;
      forever begin
         @(negedge clk);
         if (started && cmd_valid) begin
            if (exp_q.size() == 0) begin
               check({cmd_op, cmd_ext}, 80'd0, "R3 unexpected command dispatched");
               c = '0;
            end else begin
               c = exp_q.pop_front();
            end
            repeat (c.rdly) @(negedge clk);
            check({61'd0, cmd_valid, cmd_next, cmd_op}, {61'd0, 1'b1, c.n, c.op}, "R4 op/count held");
            check({16'd0, cmd_ext}, {16'd0, c.ext}, "R3 extension slots");
            cmd_ready = 1'b1;
            in_exec = 1'b1;
            @(negedge clk);
            cmd_ready = 1'b0;
            repeat (c.lat) @(negedge clk);
            res_data  = model_res(c.op, c.ext[15:0]);
            res_valid = 1'b1;
            while (!res_ready) @(negedge clk);
            @(negedge clk);
            res_valid = 1'b0;
            in_exec = 1'b0;
         end
      end
   end

   // R11: result ready only while a command is executing
   always @(negedge clk) begin
      if (started && res_ready && !in_exec)
         check({79'd0, res_ready}, 80'd0, "R11 res_ready while idle");
   end

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (4) @(negedge clk);
      check({77'd0, cmd_valid, res_ready, bit_out}, 80'd0, "R1 reset outputs");
      rst_n = 1'b1;
      @(negedge clk);
      started = 1'b1;
      check({77'd0, cmd_valid, res_ready, bit_out}, 80'd0, "R1 after reset release");

      push_cmd(16'h1230, 3'd0, 64'd0, 8'd3, 8'd0);
      xfer(16'h1230, F_IDLE, "R9 R2 idle frame");
      xfer(16'h4C02, F_BUSY, "R5 busy after completion");
      xfer(16'hBEEF, {1'b0, 16'h3012}, "R6 result one frame behind");
      push_cmd(16'h4C02, 3'd2, {32'd0, 16'h0F0F, 16'hBEEF}, 8'd3, 8'd2);
      xfer(16'h0F0F, F_IDLE, "R9 idle between extension words");
      xfer(16'h0007, F_BUSY, "R5 busy while executing");
      push_cmd(16'h0000, 3'd0, 64'd0, 8'd3, 8'd0);
      xfer(16'h0000, {1'b0, 16'hBCA3}, "R7 buffered result before error");
      xfer(16'h8884, F_ERR, "R7 error frame");
      xfer(16'h1111, {1'b0, 16'h0000}, "R6 result of no-operand command");
      xfer(16'h2222, F_IDLE, "R9 idle mid command");
      xfer(16'h3333, F_IDLE, "R9 idle mid command");
      push_cmd(16'h8884, 3'd4, {16'h4444, 16'h3333, 16'h2222, 16'h1111}, 8'd3, 8'd0);
      xfer(16'h4444, F_IDLE, "R3 four extensions");
      push_cmd(16'h7700, 3'd0, 64'd0, 8'd50, 8'd0);
      xfer(16'h7700, F_BUSY, "R5 busy");
      xfer(16'h0001, {1'b0, 16'h9599}, "R8 word sent while executing");
      push_cmd(16'hABC0, 3'd0, 64'd0, 8'd3, 8'd0);
      xfer(16'hABC0, F_BUSY, "R8 long execution still busy");
      push_cmd(16'h0000, 3'd0, 64'd0, 8'd3, 8'd0);
      xfer(16'h0000, {1'b0, 16'h0077}, "R8 discarded word ignored");
      xfer(16'h0002, {1'b0, 16'hC0AB}, "R6 result");
      xfer(16'h5555, {1'b0, 16'h0000}, "R6 result");

      for (int i = 0; i < 5; i++) begin
         @(negedge clk);
         bit_in = 1'b0;
         bit_stb = 1'b1;
         @(negedge clk);
         bit_stb = 1'b0;
      end
      @(negedge clk);
      check({79'd0, bit_out}, 80'd1, "R10 idle data bit mid frame");
      dbg_en = 1'b0;
      @(negedge clk);
      check({79'd0, bit_out}, 80'd0, "R10 status bit while disabled");
      @(negedge clk);
      dbg_en = 1'b1;

      push_cmd(16'h0010, 3'd0, 64'd0, 8'd3, 8'd0);
      xfer(16'h0010, F_IDLE, "R10 fresh frame after re-enable");
      push_cmd(16'h0000, 3'd0, 64'd0, 8'd3, 8'd0);
      xfer(16'h0000, F_BUSY, "R5 busy");
      push_cmd(16'hFFF8, 3'd0, 64'd0, 8'd3, 8'd0);
      xfer(16'hFFF8, {1'b0, 16'h1000}, "R10 abandoned command not dispatched");
      push_cmd(16'h0000, 3'd0, 64'd0, 8'd3, 8'd0);
      xfer(16'h0000, {1'b0, 16'h0000}, "R6 result");

      repeat (80) @(negedge clk);
      check({48'd0, 32'(exp_q.size())}, 80'd0, "R3 all commands dispatched");
      check({78'd0, cmd_valid, res_ready}, 80'd0, "R11 quiet at end");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule